// File: doc/BRIEF.md
# Configuration stream packet router

This block sits behind a write-only keyhole window that carries a configuration stream. Software writes 32-bit words into the window. The two word-address bits select one of four staging slots. A write to the last slot turns the four slots into one 128-bit packet and then empties the staging slots for the next packet. Slot 0 is the header. The block reads the packet type, the target row and a register address from it, then sends the packet to one of the frame-row targets. A reserved row number sends it to all the targets at once.

A counted burst mode carries raw frame data. A configuration-unit header that names the frame-data register loads a packet count from slot 1 and latches the header's row. Each of the next that-many packets is then sent unchanged to the latched row as a four-word payload, with the frame-data register address, whatever its header holds. A decompress control bit makes the block drop every committed packet. Reads of the window are handled outside and return zero.

Top module: `cfg_pkt_router`

## Requirements
- R1: `wr_word` selects the staging slot (0 to 3) that a write fills, in any order. A write to slot 3 commits slots 0 to 2 together with the incoming word as one packet. Any resulting output appears in the cycle after that write and lasts one cycle.
- R2: After every commit all staging slots read as zero. A slot that is not written before the next commit contributes zero to that packet.
- R3: In the header (slot 0), bits [31:24] are the packet type, bits [20:16] are the target row and bits [13:8] are the register address. The other header bits do not matter.
- R4: With the burst count at zero, a packet of type `FRAME_TYPE` (default 8'h81) raises `out_valid` for its row. `out_reg` is the header register address and `out_data` is {32'h0, slot3, slot2, slot1}, with slot1 in bits [31:0].
- R5: Row `BCAST_ROW` (default 31) raises every bit of `out_valid`. A row at or above `NUM_ROWS` that is not the broadcast row raises no bit.
- R6: With the count at zero, a packet of type `UNIT_TYPE` (default 8'h80) whose register address equals `BURST_REG` (default 6'h02) loads the count from slot 1 and latches the header row. It produces no output.
- R7: While the count is nonzero, each committed packet is sent to the latched row (broadcast rules apply) with `out_reg` = `BURST_REG` and `out_data` = {slot3, slot2, slot1, slot0}. Its header is not decoded, and the count falls by one.
- R8: `count_err` is set when a loaded count is not a multiple of `CNT_MULT` (default 25). The next load of a multiple clears it.
- R9: While `decompress` is high, a commit produces no output and leaves the count, the latched row and `count_err` unchanged.
- R10: After reset `out_valid` is zero, `burst_count` is zero, `count_err` is zero and the staging slots are zero.
- R11: With the count at zero, a packet of any other type, or a unit-type packet with another register address, produces no output and leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Word write strobe |
| wr_word | input | 2 | Word slot within the window (address bits [3:2]) |
| wr_data | input | 32 | Write data |
| decompress | input | 1 | Drop committed packets when high |
| out_valid | output | NUM_ROWS | One-cycle delivery strobe per row |
| out_reg | output | 6 | Register address of the delivered packet |
| out_data | output | 128 | Delivered payload |
| burst_count | output | 32 | Remaining raw burst packets |
| count_err | output | 1 | Last loaded count was not a multiple of CNT_MULT |

## Verification
The bench builds the block with its defaults: 15 rows, broadcast row 31, unit type 8'h80, frame type 8'h81, burst register 6'h02 and a multiple of 25. With these values, rows 15 to 30 are legal header values that reach no target, and the random headers hit them often. Counts of 25 and 50 run full bursts, small odd counts raise the error flag, and a burst latched on row 31 broadcasts raw data. Random headers mix the two live types, the burst register and random codes, so loads, raw packets and dropped packets interleave, and the decompress bit is toggled during bursts.

// File: rtl/cfg_pkt_router.sv
module cfg_pkt_router #(
  parameter int          NUM_ROWS   = 15,
  parameter int          BCAST_ROW  = 31,
  parameter logic [7:0]  UNIT_TYPE  = 8'h80,
  parameter logic [7:0]  FRAME_TYPE = 8'h81,
  parameter logic [5:0]  BURST_REG  = 6'h02,
  parameter int          CNT_MULT   = 25
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_word,
  input  logic [31:0]         wr_data,
  input  logic                decompress,
  output logic [NUM_ROWS-1:0] out_valid,
  output logic [5:0]          out_reg,
  output logic [127:0]        out_data,
  output logic [31:0]         burst_count,
  output logic                count_err
);
  localparam int          ROW_W  = 5;
  localparam logic [31:0] MULT_U = 32'(CNT_MULT);

  logic [31:0]      stage [3];
  logic [ROW_W-1:0] burst_row;

  wire              commit   = wr_en && (wr_word == 2'd3);
  wire              go       = commit && !decompress;
  wire [7:0]        ptype    = stage[0][31:24];
  wire [ROW_W-1:0]  hrow     = stage[0][20:16];
  wire [5:0]        hreg     = stage[0][13:8];
  wire              in_burst = burst_count != 32'd0;
  wire              do_burst = go && in_burst;
  wire              do_load  = go && !in_burst && ptype == UNIT_TYPE && hreg == BURST_REG;
  wire              do_frame = go && !in_burst && ptype == FRAME_TYPE;

  function automatic logic [NUM_ROWS-1:0] route(input logic [ROW_W-1:0] row);
    logic [NUM_ROWS-1:0] v;
    for (int r = 0; r < NUM_ROWS; r++)
      v[r] = (row == ROW_W'(BCAST_ROW)) || (row == ROW_W'(r));
    return v;
  endfunction

  for (genvar i = 0; i < 3; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                                stage[i] <= '0;
      else if (commit)                           stage[i] <= '0;
      else if (wr_en && wr_word == 2'(i))        stage[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= '0;
      out_reg     <= '0;
      out_data    <= '0;
      burst_count <= '0;
      burst_row   <= '0;
      count_err   <= 1'b0;
    end else begin
      out_valid <= '0;
      if (do_burst) begin
        out_valid   <= route(burst_row);
        out_reg     <= BURST_REG;
        out_data    <= {wr_data, stage[2], stage[1], stage[0]};
        burst_count <= burst_count - 32'd1;
      end else if (do_load) begin
        burst_count <= stage[1];
        burst_row   <= hrow;
        count_err   <= (stage[1] % MULT_U) != 32'd0;
      end else if (do_frame) begin
        out_valid <= route(hrow);
        out_reg   <= hreg;
        out_data  <= {32'h0, wr_data, stage[2], stage[1]};
      end
    end
  end

  a_r1_valid_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (|out_valid) |-> $past(commit && !decompress));

  a_r2_slots_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (stage[0] == '0 && stage[1] == '0 && stage[2] == '0));

  a_r5_one_row_or_all: assert property (@(posedge clk) disable iff (!rst_n)
    !(&out_valid) |-> $onehot0(out_valid));

  a_r6_load_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !in_burst && stage[0][31:24] == UNIT_TYPE && stage[0][13:8] == BURST_REG)
      |=> (out_valid == '0 && burst_count == $past(stage[1])));

  a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (go && burst_count != 32'd0) |=> (burst_count == $past(burst_count) - 32'd1 && out_reg == BURST_REG));

  a_r9_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && decompress) |=> (out_valid == '0 && $stable(burst_count) && $stable(count_err)));
endmodule

// File: tb/cfg_pkt_router_tb.sv
module cfg_pkt_router_tb;
  localparam int NR = 15;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, decompress = 1'b0;
  logic [1:0] wr_word = '0;
  logic [31:0] wr_data = '0;
  logic [NR-1:0] out_valid;
  logic [5:0] out_reg;
  logic [127:0] out_data;
  logic [31:0] burst_count;
  logic count_err;

  cfg_pkt_router u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
    .wr_data(wr_data), .decompress(decompress), .out_valid(out_valid), .out_reg(out_reg),
    .out_data(out_data), .burst_count(burst_count), .count_err(count_err));

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] ms [4];
  logic [31:0] mcnt = 0;
  logic [4:0]  mrow = 0;
  logic        merr = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [NR-1:0] exp_route(input logic [4:0] row);
    if (row == 5'd31) return '1;
    if (row < 5'(NR)) return NR'(1) << row;
    return '0;
  endfunction

  task automatic wr(input int slot, input logic [31:0] d);
    logic [NR-1:0] ev; logic [5:0] er; logic [127:0] ed; string tag;
    @(negedge clk);
    wr_en = 1'b1; wr_word = 2'(slot); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    ms[slot] = d;
    if (slot != 3) return;
    ev = '0; er = '0; ed = '0; tag = "R11";
    if (decompress) tag = "R9";
    else if (mcnt != 0) begin
      tag = "R7"; ev = exp_route(mrow); er = 6'h02;
      ed = {ms[3], ms[2], ms[1], ms[0]}; mcnt = mcnt - 1;
    end else if (ms[0][31:24] == 8'h80 && ms[0][13:8] == 6'h02) begin
      tag = "R6"; mcnt = ms[1]; mrow = ms[0][20:16]; merr = (ms[1] % 25) != 0;
    end else if (ms[0][31:24] == 8'h81) begin
      tag = (ms[0][20:16] == 5'd31 || ms[0][20:16] >= 5'(NR)) ? "R5" : "R4";
      ev = exp_route(ms[0][20:16]); er = ms[0][13:8]; ed = {32'h0, ms[3], ms[2], ms[1]};
    end
    for (int k = 0; k < 4; k++) ms[k] = '0;
    chk(out_valid == ev, tag, "out_valid", 128'(out_valid), 128'(ev));
    if (ev != '0) begin
      chk(out_reg == er, tag, "out_reg", 128'(out_reg), 128'(er));
      chk(out_data == ed, tag, "out_data", out_data, ed);
    end
    chk(burst_count == mcnt, tag, "burst_count", 128'(burst_count), 128'(mcnt));
    chk(count_err == merr, "R8", "count_err", 128'(count_err), 128'(merr));
    @(negedge clk);
    chk(out_valid == '0, "R1", "valid one cycle", 128'(out_valid), 128'(0));
  endtask

  task automatic pkt(input logic [31:0] h, input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    wr(0, h); wr(1, a); wr(2, b); wr(3, c);
  endtask

  function automatic logic [31:0] hdr(input logic [7:0] t, input logic [4:0] row, input logic [5:0] rg);
    return {t, 3'b101, row, 2'b11, rg, 8'h5A};
  endfunction

  initial begin
    for (int k = 0; k < 4; k++) ms[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == '0, "R10", "reset valid", 128'(out_valid), 0);
    chk(burst_count == 0, "R10", "reset count", 128'(burst_count), 0);
    chk(count_err == 0, "R10", "reset err", 128'(count_err), 0);
    wr(3, 32'h1111_2222);  // R10: empty slots give type 0 -> dropped, nothing out
    pkt(hdr(8'h81, 5'd3, 6'h15), 32'hA1, 32'hA2, 32'hA3);   // R3 R4
    pkt(hdr(8'h81, 5'd14, 6'h3F), 32'hB1, 32'hB2, 32'hB3);  // R4 top row
    wr(2, 32'hC2); wr(1, 32'hC1); wr(0, hdr(8'h81, 5'd0, 6'h01)); wr(3, 32'hC3); // R1 order
    wr(0, hdr(8'h81, 5'd5, 6'h07)); wr(3, 32'hD3);          // R2 slots 1,2 zero
    pkt(hdr(8'h81, 5'd31, 6'h09), 32'hE1, 32'hE2, 32'hE3);  // R5 broadcast
    pkt(hdr(8'h81, 5'd20, 6'h09), 32'hF1, 32'hF2, 32'hF3);  // R5 absent row
    pkt(hdr(8'h80, 5'd4, 6'h03), 32'd9, 32'h0, 32'h0);      // R11 unit, other reg
    pkt(hdr(8'h42, 5'd4, 6'h02), 32'd9, 32'h0, 32'h0);      // R11 other type
    pkt(hdr(8'h80, 5'd7, 6'h02), 32'd50, 32'h0, 32'h0);     // R6 load 50
    for (int i = 0; i < 50; i++)                            // R7 raw burst
      pkt(hdr(8'h81, 5'd2, 6'h11), $urandom, $urandom, $urandom);
    pkt(hdr(8'h80, 5'd31, 6'h02), 32'd7, 32'h0, 32'h0);     // R8 bad count, broadcast row
    decompress = 1'b1;
    pkt(hdr(8'h81, 5'd1, 6'h01), 32'h1, 32'h2, 32'h3);      // R9 during burst
    decompress = 1'b0;
    for (int i = 0; i < 7; i++) pkt($urandom, $urandom, $urandom, $urandom); // R7
    pkt(hdr(8'h80, 5'd9, 6'h02), 32'd25, 32'h0, 32'h0);     // R8 cleared
    for (int i = 0; i < 25; i++) pkt($urandom, $urandom, $urandom, $urandom);
    decompress = 1'b1;
    pkt(hdr(8'h81, 5'd1, 6'h01), 32'h1, 32'h2, 32'h3);      // R9 idle
    decompress = 1'b0;
    void'($urandom(32'd1234));
    for (int i = 0; i < 400; i++) begin
      logic [7:0] t; logic [5:0] rg; logic [31:0] cv; int sel;
      sel = $urandom % 8;
      t = (sel < 4) ? 8'h81 : (sel < 6) ? 8'h80 : 8'($urandom);
      rg = ($urandom % 2) ? 6'h02 : 6'($urandom);
      sel = $urandom % 4;
      cv = (sel == 0) ? 32'd25 : (sel == 1) ? 32'd0 : 32'($urandom % 9);
      decompress = ($urandom % 10) == 0;
      pkt(hdr(t, 5'($urandom), rg), cv, $urandom, $urandom);
    end
    decompress = 1'b0;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule